// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives one pulse-width-modulated output from a single clock. An 8-bit period timer, widened by two sub-count bits into a 10-bit running count, steps once every prescale clocks and restarts when the timer portion has reached a programmable period limit and the sub-count is at its last value. A 10-bit duty value sets how many count steps the output stays high in each period.

Software writes the period limit, the upper eight and lower two duty bits, and the prescale select through a small write port. The duty value goes into a shadow register only when a period ends, so writing the duty at any moment cannot produce a runt or stretched pulse. The shadow value and the timer are both visible on output ports. A zero duty produces no pulse at all. A duty at or above the period length keeps the output high for the whole period.

Top module: `pwm_gen`

## Requirements
- R1: One period lasts (P+1)·4·D clocks, where P is the period limit and D is the prescale divide. Select codes 0, 1, 2 and 3 give D = 1, 4, 16 and 16.
- R2: The output is high for duty·D clocks of each period. The duty is the 10-bit value {upper byte, lower two bits}.
- R3: A write with `wr_en` high stores `wr_data` by address. Address 0 is the period limit, 1 is duty bits 9:2, 2 is duty bits 1:0 taken from `wr_data[1:0]`, and 3 is the prescale select taken from `wr_data[1:0]`.
- R4: `duty_shadow` changes only at a period end, where it takes the written duty. A duty written during a period leaves that period's pulse unchanged.
- R5: When the duty taken at a period end is zero, the output is not raised for that period.
- R6: When the duty is at least (P+1)·4, the output stays high for the whole period.
- R7: While `rst` is high, the output, timer, shadow duty and all written settings are cleared on each clock.
- R8: With `en` low, the timer holds and the output is low from the next clock. After `en` returns high, the output first rises at the next period end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable |
| wr_en | input | 1 | Setting write strobe |
| wr_addr | input | 2 | Setting select |
| wr_data | input | 8 | Setting write data |
| pwm_out | output | 1 | Registered PWM output |
| duty_shadow | output | 10 | Duty value in effect for the current period |
| timer_value | output | 8 | Period timer |

## Verification
The hardest case to reach is a duty rewrite that lands in the middle of a period, because its effect has to be seen before the next boundary. The bench syncs to a rising edge and rewrites both duty fields a few clocks later. At a sample point where the old and new duty predict different output levels, it checks that the output still follows the old value and that the shadow still reads the old duty. It also walks the duty across the period length (one below, equal, far above) with the shortest prescale, so the never-cleared case and the last normal case fall next to each other.

// File: rtl/pwm_gen_pkg.sv
`timescale 1ns/1ps
package pwm_gen_pkg;
  localparam int PRE_W = 4;
  localparam int SEL_W = 2;

  typedef enum logic [1:0] {
    SET_PERIOD  = 2'd0,
    SET_DUTY_HI = 2'd1,
    SET_DUTY_LO = 2'd2,
    SET_PRESC   = 2'd3
  } set_addr_e;

  // last prescaler count before a tick: divide 1, 4, 16, 16
  function automatic logic [PRE_W-1:0] presc_last(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    presc_last = 4'd0;
      2'd1:    presc_last = 4'd3;
      default: presc_last = 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/pwm_gen_regs.sv
`timescale 1ns/1ps
module pwm_gen_regs
  import pwm_gen_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [1:0]              wr_addr,
  input  logic [TMR_W-1:0]        wr_data,
  output logic [TMR_W-1:0]        period_q,
  output logic [TMR_W+FRAC_W-1:0] duty_q,
  output logic [SEL_W-1:0]        sel_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      duty_q   <= '0;
      sel_q    <= '0;
    end else if (wr_en) begin
      case (set_addr_e'(wr_addr))
        SET_PERIOD:  period_q <= wr_data;
        SET_DUTY_HI: duty_q[TMR_W+FRAC_W-1:FRAC_W] <= wr_data;
        SET_DUTY_LO: duty_q[FRAC_W-1:0] <= wr_data[FRAC_W-1:0];
        default:     sel_q <= wr_data[SEL_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/pwm_gen_presc.sv
`timescale 1ns/1ps
module pwm_gen_presc
  import pwm_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] last;

  assign last = presc_last(sel);
  // >= keeps a select change from stranding the counter above its new limit
  assign tick = en && (pre_cnt >= last);

  always_ff @(posedge clk) begin
    if (rst)       pre_cnt <= '0;
    else if (tick) pre_cnt <= '0;
    else if (en)   pre_cnt <= pre_cnt + 1'b1;
  end

  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pre_cnt)); // R8
endmodule

// File: rtl/pwm_gen_timebase.sv
`timescale 1ns/1ps
module pwm_gen_timebase #(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  localparam int CW    = TMR_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [TMR_W-1:0] period,
  output logic [CW-1:0]    cnt_q,
  output logic [CW-1:0]    cnt_nxt,
  output logic             wrap
);
  logic [TMR_W-1:0]  tmr;
  logic [FRAC_W-1:0] frac;

  assign tmr  = cnt_q[CW-1:FRAC_W];
  assign frac = cnt_q[FRAC_W-1:0];
  // >= ends the period at once if the limit was lowered below the timer
  assign wrap    = tick && (tmr >= period) && (&frac);
  assign cnt_nxt = wrap ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= cnt_nxt;
  end

  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt_q == '0)); // R1
  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/pwm_gen_output.sv
`timescale 1ns/1ps
module pwm_gen_output #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              wrap,
  input  logic [DUTY_W-1:0] cnt_nxt,
  input  logic [DUTY_W-1:0] duty,
  output logic [DUTY_W-1:0] shadow_q,
  output logic              pwm_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      pwm_q    <= 1'b0;
    end else if (!en) begin
      pwm_q <= 1'b0;
    end else if (wrap) begin
      shadow_q <= duty;
      pwm_q    <= (duty != '0);
    end else if (tick && (cnt_nxt == shadow_q)) begin
      pwm_q <= 1'b0;
    end
  end

  AST_SHADOW_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(shadow_q)); // R4
  AST_ZERO_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (wrap && (duty == '0)) |=> !pwm_q); // R5
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_q); // R8
  AST_RISE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_q) |-> $past(wrap)); // R8
endmodule

// File: rtl/pwm_gen.sv
`timescale 1ns/1ps
module pwm_gen
  import pwm_gen_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  localparam int DUTY_W = TMR_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [TMR_W-1:0]  wr_data,
  output logic              pwm_out,
  output logic [DUTY_W-1:0] duty_shadow,
  output logic [TMR_W-1:0]  timer_value
);
  logic [TMR_W-1:0]  period_q;
  logic [DUTY_W-1:0] duty_q;
  logic [SEL_W-1:0]  sel_q;
  logic              tick;
  logic              wrap;
  logic [DUTY_W-1:0] cnt_q;
  logic [DUTY_W-1:0] cnt_nxt;

  pwm_gen_regs #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .period_q(period_q), .duty_q(duty_q), .sel_q(sel_q)
  );

  pwm_gen_presc u_presc (
    .clk(clk), .rst(rst), .en(en), .sel(sel_q), .tick(tick)
  );

  pwm_gen_timebase #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_tb (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .period(period_q),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .wrap(wrap)
  );

  pwm_gen_output #(.DUTY_W(DUTY_W)) u_out (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .wrap(wrap),
    .cnt_nxt(cnt_nxt), .duty(duty_q), .shadow_q(duty_shadow), .pwm_q(pwm_out)
  );

  assign timer_value = cnt_q[DUTY_W-1:FRAC_W];
endmodule

// File: tb/sim_pwm_gen.sv
`timescale 1ns/1ps
module sim_pwm_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out;
  logic [9:0] duty_shadow;
  logic [7:0] timer_value;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  pwm_gen u0 (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .duty_shadow(duty_shadow),
    .timer_value(timer_value)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R3: duty bits 9:2 at address 1, bits 1:0 at address 2
  task automatic set_duty(input int v);
    wr(2'd1, 8'(v >> 2));
    wr(2'd2, 8'(v & 3));
  endtask

  task automatic wait_rise(input string req);
    bit prev;
    bit ok = 0;
    for (int i = 0; i < 20000; i++) begin
      prev = pwm_out;
      @(negedge clk);
      if (!prev && pwm_out) begin ok = 1; break; end
    end
    check(ok, {req, " rise seen"}, int'(ok), 1);
  endtask

  task automatic measure(output int hi, output int len);
    bit prev;
    hi = 0; len = 0;
    do begin
      if (pwm_out) hi++;
      len++;
      prev = pwm_out;
      @(negedge clk);
    end while (!(!prev && pwm_out) && len < 20000);
  endtask

  task automatic run_case(input string req, input int p, input int sel, input int duty,
                          input int exp_hi, input int exp_len);
    int hi, len;
    wr(2'd0, 8'(p));
    wr(2'd3, 8'(sel));
    set_duty(duty);
    wait_rise(req);
    wait_rise(req);
    check(duty_shadow == 10'(duty), {req, " shadow"}, duty_shadow, duty);
    measure(hi, len);
    check(hi == exp_hi, {req, " high clocks R2"}, hi, exp_hi);
    check(len == exp_len, {req, " period clocks R1"}, len, exp_len);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0, "R7 output", pwm_out, 0);
    check(duty_shadow == 10'd0, "R7 shadow", duty_shadow, 0);
    check(timer_value == 8'd0, "R7 timer", timer_value, 0);
    rst = 1'b0;
    en  = 1'b1;
  endtask

  task automatic t_basic();
    run_case("R1 R2 R3 div1", 9, 0, 20, 20, 40);
    run_case("R2 low bits", 9, 0, 23, 23, 40);
    run_case("R1 div4", 9, 1, 23, 92, 160);
  endtask

  task automatic t_presc();
    run_case("R1 sel2 div16", 1, 2, 5, 80, 128);
    run_case("R1 sel3 div16", 3, 3, 10, 160, 256);
  endtask

  task automatic t_dbuf();
    int hi, len;
    run_case("R4 setup", 9, 0, 20, 20, 40);
    wait_rise("R4");
    set_duty(10);
    check(duty_shadow == 10'd20, "R4 shadow held mid period", duty_shadow, 20);
    repeat (10) @(negedge clk);
    check(pwm_out == 1'b1, "R4 old duty still in force", pwm_out, 1);
    wait_rise("R4");
    check(duty_shadow == 10'd10, "R4 shadow after period end", duty_shadow, 10);
    measure(hi, len);
    check(hi == 10, "R4 new duty high clocks", hi, 10);
    check(len == 40, "R4 period clocks", len, 40);
  endtask

  task automatic t_zero();
    int highs = 0;
    set_duty(0);
    repeat (100) @(negedge clk);
    check(duty_shadow == 10'd0, "R5 shadow zero", duty_shadow, 0);
    for (int i = 0; i < 120; i++) begin
      if (pwm_out) highs++;
      @(negedge clk);
    end
    check(highs == 0, "R5 no pulse", highs, 0);
  endtask

  task automatic t_over();
    int lows = 0;
    int hi, len;
    wr(2'd0, 8'd3);
    wr(2'd3, 8'd0);
    set_duty(40);
    wait_rise("R6");
    check(duty_shadow == 10'd40, "R6 shadow", duty_shadow, 40);
    for (int i = 0; i < 48; i++) begin
      if (!pwm_out) lows++;
      @(negedge clk);
    end
    check(lows == 0, "R6 duty above period stays high", lows, 0);
    set_duty(16);
    repeat (40) @(negedge clk);
    lows = 0;
    for (int i = 0; i < 48; i++) begin
      if (!pwm_out) lows++;
      @(negedge clk);
    end
    check(lows == 0, "R6 duty equal to period stays high", lows, 0);
    set_duty(15);
    wait_rise("R6");
    wait_rise("R6");
    measure(hi, len);
    check(hi == 15, "R6 one below period high clocks", hi, 15);
    check(len == 16, "R6 one below period length", len, 16);
  endtask

  task automatic t_disable();
    logic [7:0] t0;
    int hi, len;
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(pwm_out == 1'b0, "R8 output low when off", pwm_out, 0);
    t0 = timer_value;
    repeat (20) @(negedge clk);
    check(timer_value == t0, "R8 timer holds", timer_value, t0);
    check(pwm_out == 1'b0, "R8 output stays low", pwm_out, 0);
    en = 1'b1;
    @(negedge clk);
    check(pwm_out == 1'b0, "R8 low until period end", pwm_out, 0);
    wait_rise("R8");
    measure(hi, len);
    check(hi == 15 && len == 16, "R8 resumes period", hi, 15);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_presc();
    t_dbuf();
    t_zero();
    t_over();
    t_disable();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule